// File: doc/BRIEF.md
# Paging Address Translator with Translation Cache

This block sits between a processor and memory and maps 16-bit logical addresses onto physical addresses through one level of paging. Pages are 1 KB: the upper six address bits select a page and the lower ten bits pass through unchanged as the offset inside it. The frame for a page comes from a small fully associative cache of recent page-to-frame pairs. When the cache has no entry for the page, the frame is fetched from a page table held in memory. That table starts at a programmable base address and covers a programmable number of pages.

The processor hands over one request at a time on a valid/ready port. The result comes back as a one-cycle response pulse that carries either the physical address or a fault code. A page number outside the table length faults at once, with no memory read. A table entry whose valid bit is clear also faults, and it is never cached. System software writes the base and length registers and pulses the flush input on every context switch so that no translation from the previous process survives.

Top module: `page_mmu`

## Requirements
- R1: The physical address is the 6-bit frame number in bits 15:10 followed by the unchanged logical bits 9:0; the page number is logical bits 15:10.
- R2: A request whose page number is greater than or equal to the length register responds in the cycle after acceptance with fault code 2'b01 and issues no memory read.
- R3: A request that hits in the cache responds in the cycle after acceptance with fault code 2'b00 and issues no memory read.
- R4: A miss issues exactly one memory read at base plus page number. The read request is held with a stable address until read data is returned, and the response follows in the cycle after the data.
- R5: A table entry has its valid bit at bit 15 and its frame number in bits 5:0. An entry with bit 15 clear responds with fault code 2'b10 and is not cached, so a repeat of that request reads memory again.
- R6: A valid entry fetched on a miss is cached, so a later request to the same page hits.
- R7: The cache holds 8 entries, and fills replace them in circular order, so the ninth distinct fill evicts the oldest of the previous eight.
- R8: A flush pulse invalidates every cached entry, so that each page misses on its next access.
- R9: A flush during an outstanding table read prevents that read's entry from being cached, although the response is still delivered.
- R10: The request port accepts only when no translation is outstanding: ready is low while a table read is pending.
- R11: After reset, ready is high, no response or memory read is pending, and base and length are zero, so every request faults with code 2'b01.
- R12: Writes to the base and length registers take effect for requests accepted after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_laddr_i | input | 16 | Logical address |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_paddr_o | output | 16 | Physical address (zero on fault) |
| rsp_fault_o | output | 2 | 00 none, 01 beyond length, 10 invalid entry |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 16 | New table base address |
| len_we_i | input | 1 | Length register write strobe |
| len_wdata_i | input | 7 | New table length in entries (0 to 64) |
| flush_i | input | 1 | Invalidate all cached translations |
| mem_req_o | output | 1 | Table read request, held until data |
| mem_addr_o | output | 16 | Table entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Table entry read data |

## Verification
On every cycle, the assertions check that at most one cache entry matches a page, that the cache is empty after a flush, and that the memory request stays steady until its data arrives. They also check that ready is low during a table read, that an out-of-range request faults on the next cycle, and that an invalid entry leads to an invalid-entry fault and no fill. Only the bench scenarios can show the circular replacement order across nine fills, the effect of a flush in the middle of a walk on a later access, the exact addresses built from base and page, and the frame and offset assembled for several pages.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_LEN  = 2'b01,
    FLT_INV  = 2'b10
  } fault_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_WALK = 1'b1
  } walk_st_e;
endpackage

// File: rtl/mmu_cfg.sv
module mmu_cfg #(
  parameter int MA_W  = 16,
  parameter int LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic [MA_W-1:0]  base_wdata_i,
  input  logic             len_we_i,
  input  logic [LEN_W-1:0] len_wdata_i,
  output logic [MA_W-1:0]  base_o,
  output logic [LEN_W-1:0] len_o
);
  logic [MA_W-1:0]  base_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (base_we_i) base_q <= base_wdata_i;
      if (len_we_i)  len_q  <= len_wdata_i;
    end
  end

  assign base_o = base_q;
  assign len_o  = len_q;

  // R12
  base_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_i |=> base_o == $past(base_wdata_i));
  // R12
  len_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_we_i |=> len_o == $past(len_wdata_i));
endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb #(
  parameter int PN_W  = 6,
  parameter int FN_W  = 6,
  parameter int N_ENT = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PN_W-1:0] lk_page_i,
  output logic            lk_hit_o,
  output logic [FN_W-1:0] lk_frame_o,
  input  logic            flush_i,
  input  logic            fill_en_i,
  input  logic [PN_W-1:0] fill_page_i,
  input  logic [FN_W-1:0] fill_frame_i
);
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam logic [IW-1:0] LAST = IW'(N_ENT - 1);

  logic [N_ENT-1:0] vld_q;
  logic [PN_W-1:0]  tag_q [N_ENT];
  logic [FN_W-1:0]  frm_q [N_ENT];
  logic [IW-1:0]    rr_q;
  logic [N_ENT-1:0] hit_vec;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_page_i);
  end

  always_comb begin
    lk_frame_o = '0;
    for (int i = 0; i < N_ENT; i++)
      if (hit_vec[i]) lk_frame_o = lk_frame_o | frm_q[i];
  end
  assign lk_hit_o = |hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (fill_en_i) begin
      vld_q[rr_q] <= 1'b1;
      rr_q        <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i && !flush_i) begin
      tag_q[rr_q] <= fill_page_i;
      frm_q[rr_q] <= fill_frame_i;
    end
  end

  // R3
  one_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> vld_q == '0);
  // R6
  fill_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !flush_i) |=> vld_q != '0);
endmodule

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
  import mmu_pkg::*;
#(
  parameter int LA_W      = 16,
  parameter int OFF_W     = 10,
  parameter int FN_W      = 6,
  parameter int PTE_W     = 16,
  parameter int PTE_V_BIT = 15,
  parameter int MA_W      = 16,
  localparam int PN_W     = LA_W - OFF_W,
  localparam int PA_W     = FN_W + OFF_W,
  localparam int LEN_W    = PN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LA_W-1:0]  req_laddr_i,
  output logic             req_ready_o,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [1:0]       rsp_fault_o,
  input  logic [MA_W-1:0]  base_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             flush_i,
  output logic [PN_W-1:0]  lk_page_o,
  input  logic             lk_hit_i,
  input  logic [FN_W-1:0]  lk_frame_i,
  output logic             fill_en_o,
  output logic [PN_W-1:0]  fill_page_o,
  output logic [FN_W-1:0]  fill_frame_o,
  output logic             mem_req_o,
  output logic [MA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  walk_st_e         st_q;
  logic [PN_W-1:0]  page_q;
  logic [OFF_W-1:0] off_q;
  logic [MA_W-1:0]  addr_q;
  logic             kill_q;
  logic             rsp_v_q;
  logic [PA_W-1:0]  rsp_pa_q;
  logic [1:0]       rsp_f_q;

  logic [PN_W-1:0]  in_page;
  logic [OFF_W-1:0] in_off;
  logic             accept, beyond, pte_ok;

  assign in_page = req_laddr_i[LA_W-1:OFF_W];
  assign in_off  = req_laddr_i[OFF_W-1:0];
  assign accept  = req_valid_i && (st_q == S_IDLE);
  assign beyond  = {1'b0, in_page} >= len_i;
  assign pte_ok  = mem_rdata_i[PTE_V_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      page_q   <= '0;
      off_q    <= '0;
      addr_q   <= '0;
      kill_q   <= 1'b0;
      rsp_v_q  <= 1'b0;
      rsp_pa_q <= '0;
      rsp_f_q  <= FLT_NONE;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (accept) begin
            page_q <= in_page;
            off_q  <= in_off;
            kill_q <= 1'b0;
            if (beyond) begin
              rsp_v_q  <= 1'b1;
              rsp_f_q  <= FLT_LEN;
              rsp_pa_q <= '0;
            end else if (lk_hit_i) begin
              rsp_v_q  <= 1'b1;
              rsp_f_q  <= FLT_NONE;
              rsp_pa_q <= {lk_frame_i, in_off};
            end else begin
              st_q   <= S_WALK;
              addr_q <= base_i + MA_W'(in_page);
            end
          end
        end
        S_WALK: begin
          if (flush_i) kill_q <= 1'b1;
          if (mem_rvalid_i) begin
            st_q    <= S_IDLE;
            rsp_v_q <= 1'b1;
            if (pte_ok) begin
              rsp_f_q  <= FLT_NONE;
              rsp_pa_q <= {mem_rdata_i[FN_W-1:0], off_q};
            end else begin
              rsp_f_q  <= FLT_INV;
              rsp_pa_q <= '0;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st_q == S_IDLE);
  assign rsp_valid_o  = rsp_v_q;
  assign rsp_paddr_o  = rsp_pa_q;
  assign rsp_fault_o  = rsp_f_q;
  assign lk_page_o    = in_page;
  assign mem_req_o    = (st_q == S_WALK);
  assign mem_addr_o   = addr_q;
  // cached only when valid and no flush seen since the walk began
  assign fill_en_o    = (st_q == S_WALK) && mem_rvalid_i && pte_ok && !kill_q && !flush_i;
  assign fill_page_o  = page_q;
  assign fill_frame_o = mem_rdata_i[FN_W-1:0];

  // R2
  len_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && beyond) |=> rsp_valid_o && rsp_fault_o == FLT_LEN && !mem_req_o);
  // R3
  accept_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (rsp_valid_o || mem_req_o));
  // R4
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> mem_req_o && $stable(mem_addr_o));
  // R4
  walk_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> rsp_valid_o && !mem_req_o);
  // R5
  inv_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i && !mem_rdata_i[PTE_V_BIT]) |-> !fill_en_o ##1 rsp_fault_o == FLT_INV);
  // R9
  flush_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && flush_i && !mem_rvalid_i) |=> !fill_en_o);
  // R10
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

// File: rtl/page_mmu.sv
module page_mmu #(
  parameter int LA_W      = 16,
  parameter int OFF_W     = 10,
  parameter int FN_W      = 6,
  parameter int N_ENT     = 8,
  parameter int PTE_W     = 16,
  parameter int PTE_V_BIT = 15,
  parameter int MA_W      = 16,
  localparam int PN_W     = LA_W - OFF_W,
  localparam int PA_W     = FN_W + OFF_W,
  localparam int LEN_W    = PN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [LA_W-1:0]  req_laddr_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [1:0]       rsp_fault_o,
  input  logic             base_we_i,
  input  logic [MA_W-1:0]  base_wdata_i,
  input  logic             len_we_i,
  input  logic [LEN_W-1:0] len_wdata_i,
  input  logic             flush_i,
  output logic             mem_req_o,
  output logic [MA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  logic [MA_W-1:0]  base;
  logic [LEN_W-1:0] len;
  logic [PN_W-1:0]  lk_page, fill_page;
  logic [FN_W-1:0]  lk_frame, fill_frame;
  logic             lk_hit, fill_en;

  mmu_cfg #(.MA_W(MA_W), .LEN_W(LEN_W)) i_cfg (
    .clk_i, .rst_ni,
    .base_we_i, .base_wdata_i, .len_we_i, .len_wdata_i,
    .base_o(base), .len_o(len)
  );

  mmu_tlb #(.PN_W(PN_W), .FN_W(FN_W), .N_ENT(N_ENT)) i_tlb (
    .clk_i, .rst_ni,
    .lk_page_i(lk_page), .lk_hit_o(lk_hit), .lk_frame_o(lk_frame),
    .flush_i,
    .fill_en_i(fill_en), .fill_page_i(fill_page), .fill_frame_i(fill_frame)
  );

  mmu_ctrl #(
    .LA_W(LA_W), .OFF_W(OFF_W), .FN_W(FN_W),
    .PTE_W(PTE_W), .PTE_V_BIT(PTE_V_BIT), .MA_W(MA_W)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_laddr_i, .req_ready_o,
    .rsp_valid_o, .rsp_paddr_o, .rsp_fault_o,
    .base_i(base), .len_i(len), .flush_i,
    .lk_page_o(lk_page), .lk_hit_i(lk_hit), .lk_frame_i(lk_frame),
    .fill_en_o(fill_en), .fill_page_o(fill_page), .fill_frame_o(fill_frame),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i
  );

  // R11
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> req_ready_o && !rsp_valid_o && !mem_req_o);
  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && lk_hit && ({1'b0, lk_page} < len))
      |=> rsp_paddr_o[OFF_W-1:0] == $past(req_laddr_i[OFF_W-1:0]));
endmodule

// File: tb/test_page_mmu.sv
module test_page_mmu;
  localparam int LAT = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [15:0] req_laddr_i = '0;
  logic        rsp_valid_o;
  logic [15:0] rsp_paddr_o;
  logic [1:0]  rsp_fault_o;
  logic        base_we_i = 1'b0;
  logic [15:0] base_wdata_i = '0;
  logic        len_we_i = 1'b0;
  logic [6:0]  len_wdata_i = '0;
  logic        flush_i = 1'b0;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;

  page_mmu i_page_mmu (.*);

  always #5 clk_i = ~clk_i;

  logic [15:0] mem_arr [256];
  int rd_cnt = 0;
  int mem_cnt = 0;
  logic [15:0] last_addr = '0;
  int n_chk = 0, n_fail = 0;
  bit bad_ready = 0;

  always @(posedge clk_i) begin
    if (mem_rvalid_i) mem_rvalid_i <= 1'b0;
    else if (mem_req_o) begin
      if (mem_cnt == LAT - 1) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= mem_arr[mem_addr_o[7:0]];
        last_addr    <= mem_addr_o;
        rd_cnt       <= rd_cnt + 1;
        mem_cnt      <= 0;
      end else mem_cnt <= mem_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic run_req(input logic [15:0] la, input bit flush_mid,
                         output logic [15:0] pa, output logic [1:0] flt,
                         output int lat, output int reads);
    int r0;
    r0 = rd_cnt;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    req_laddr_i = la;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 1;
    if (flush_mid && mem_req_o && !rsp_valid_o) begin
      flush_i = 1'b1;
      @(negedge clk_i);
      flush_i = 1'b0;
      lat++;
    end
    while (!rsp_valid_o && lat < 50) begin
      if (mem_req_o && req_ready_o) bad_ready = 1;
      @(negedge clk_i);
      lat++;
    end
    pa = rsp_paddr_o;
    flt = rsp_fault_o;
    reads = rd_cnt - r0;
  endtask

  task automatic wr_base(input logic [15:0] v);
    @(negedge clk_i); base_we_i = 1'b1; base_wdata_i = v;
    @(negedge clk_i); base_we_i = 1'b0;
  endtask

  task automatic wr_len(input logic [6:0] v);
    @(negedge clk_i); len_we_i = 1'b1; len_wdata_i = v;
    @(negedge clk_i); len_we_i = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
  endtask

  // {logical, expected physical, fault, expects a table read}
  localparam logic [34:0] VEC [10] = '{
    {16'h0000, 16'h0C00, 2'd0, 1'b1},
    {16'h03FF, 16'h0FFF, 2'd0, 1'b0},
    {16'h0C15, 16'h4815, 2'd0, 1'b1},
    {16'h0C16, 16'h4816, 2'd0, 1'b0},
    {16'h1C00, 16'h0000, 2'd2, 1'b1},
    {16'h1C00, 16'h0000, 2'd2, 1'b1},
    {16'h3000, 16'h0000, 2'd1, 1'b0},
    {16'hFC00, 16'h0000, 2'd1, 1'b0},
    {16'h2FFF, 16'hEBFF, 2'd0, 1'b1},
    {16'h2C01, 16'hE801, 2'd0, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    logic [15:0] pa;
    logic [1:0]  flt;
    int lat, rd;
    for (int i = 0; i < 256; i++) mem_arr[i] = 16'h0000;
    for (int p = 0; p < 64; p++) mem_arr[8'h40 + p] = {1'b1, 9'b0, 6'((p * 5 + 3) % 64)};
    mem_arr[8'h47] = 16'h0005;
    mem_arr[8'h81] = 16'h802A;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    check(req_ready_o == 1'b1, "R11 ready", req_ready_o, 1);
    check(rsp_valid_o == 1'b0 && mem_req_o == 1'b0, "R11 idle", {rsp_valid_o, mem_req_o}, 0);
    run_req(16'h0000, 0, pa, flt, lat, rd);
    check(flt == 2'd1 && rd == 0, "R11 zero length faults", {flt, 4'(rd)}, 6'h10);

    wr_base(16'h0040);
    wr_len(7'd12);

    for (int v = 0; v < 10; v++) begin
      run_req(VEC[v][34:19], 0, pa, flt, lat, rd);
      check(flt == VEC[v][2:1], "R2/R5 fault code", flt, VEC[v][2:1]);
      if (VEC[v][2:1] == 2'd0) check(pa == VEC[v][18:3], "R1 physical address", pa, VEC[v][18:3]);
      check(rd == int'(VEC[v][0]), "R3/R4/R6 table reads", rd, VEC[v][0]);
      if (!VEC[v][0]) check(lat == 1, "R2/R3 latency", lat, 1);
      else check(lat == LAT + 2, "R4 miss latency", lat, LAT + 2);
    end

    // R4 address base + page
    run_req(16'h1400, 0, pa, flt, lat, rd);
    check(last_addr == 16'h0045, "R4 table address", last_addr, 16'h0045);
    check(pa == 16'h7000, "R1 page 5", pa, 16'h7000);

    // R8 flush empties cache
    do_flush();
    run_req(16'h0000, 0, pa, flt, lat, rd);
    check(rd == 1, "R8 miss after flush", rd, 1);

    // R7 circular replacement
    do_flush();
    for (int p = 0; p < 10; p++) begin
      if (p == 7) continue;
      run_req(16'(p << 10), 0, pa, flt, lat, rd);
      check(rd == 1, "R7 fill miss", rd, 1);
    end
    run_req(16'h0800, 0, pa, flt, lat, rd);
    check(rd == 0, "R7 page 2 kept", rd, 0);
    run_req(16'h2000, 0, pa, flt, lat, rd);
    check(rd == 0, "R7 page 8 kept", rd, 0);
    run_req(16'h0000, 0, pa, flt, lat, rd);
    check(rd == 1, "R7 oldest evicted", rd, 1);

    // R9 flush mid-walk: response delivered, entry not kept
    do_flush();
    run_req(16'h0C00, 1, pa, flt, lat, rd);
    check(flt == 2'd0 && pa == 16'h4800, "R9 response", pa, 16'h4800);
    run_req(16'h0C00, 0, pa, flt, lat, rd);
    check(rd == 1, "R9 not cached", rd, 1);
    run_req(16'h0C00, 0, pa, flt, lat, rd);
    check(rd == 0, "R6 cached after clean walk", rd, 0);
    // R10
    check(bad_ready == 0, "R10 ready during walk", bad_ready, 0);

    // R12 new base and length
    wr_base(16'h0080);
    do_flush();
    run_req(16'h0400, 0, pa, flt, lat, rd);
    check(last_addr == 16'h0081, "R12 base applied", last_addr, 16'h0081);
    check(pa == 16'hA800, "R12 frame from new table", pa, 16'hA800);
    wr_len(7'd2);
    run_req(16'h0800, 0, pa, flt, lat, rd);
    check(flt == 2'd1 && rd == 0, "R12 length applied", flt, 1);

    summary();
  end
endmodule